// File: doc/BRIEF.md
# Pre-framed Serial Message Sender

This block sends one fixed four-character message as a serial bit stream, starting when an external start latch goes high. A fast free-running clock passes through two divider stages. The first divides by 10 and the second by 8, so one bit lasts 80 fast-clock cycles (7 kHz from 560 kHz). Each divided tick moves an address pointer one step through a small bit table. The table is built from the four character codes and stores the start, data and stop bits of every frame already in place.

The table drives three outputs. The first is the serial line. The second is an end mark: it stops the first divider at the final address, so the pointer stays there until the start latch is withdrawn. The third is a guard level. Logic outside the block uses it to stop the start latch from being cleared while the message is in progress. Address 0 is the idle state. Addresses 1 to 53 carry the 53 message bits, and address 54 is the terminal state. The line rests at mark (high) at address 0 and at address 54.

Top module: `msg_rom_tx`

## Requirements
- R1: While `rst` is high, or `start` is low, the pointer is held at address 0. One clock edge later, `sdata` is 1, `done` is 0 and `guard` is 1.
- R2: While `start` is high and the terminal address has not been reached, the pointer advances by one every DIV_A*DIV_B = 80 clock cycles. The first step happens on the 80th edge that samples `start` high.
- R3: Message bit index b = address-1 (0..52) falls in character k = b/14 at position p = b%14. Position 0 is the start bit (0). Positions 1..9 carry code bit p-1, least significant bit first. Positions 10..13 are stop or gap marks (1). The last character ends after position 10, which gives 53 bits.
- R4: The pointer stops at address 54 and stays there while `start` remains high. At that address `sdata` is 1.
- R5: `guard` is high at addresses 0 and 54 and low at every address from 1 to 53.
- R6: When `start` falls at any address, including partway through the message, the pointer returns to address 0 on the next edge. The next rise of `start` replays the message from the beginning.
- R7: `sdata` is registered. It shows the table bit of the address held before each edge, so it changes one clock after the pointer does.
- R8: `done` is high exactly when the pointer is at address 54.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | State of the external start latch |
| sdata | output | 1 | Serial line, 1 = mark, 0 = space |
| done | output | 1 | Pointer is at the terminal address |
| guard | output | 1 | Low while the message is in progress |

## Verification
The checker tests on every cycle that a low `start` returns the block to idle. It also checks that `done` implies a marking line and a high `guard`, and that the terminal state holds steady while `start` stays high. It checks that `guard` only falls and `done` only rises while `start` is held. The exact bit pattern, the 80-cycle bit spacing and the one-cycle lag of the registered line only show against the bench's cycle model. That model builds its expected frames by concatenation and compares them over full messages, aborted messages and reset pulses.

// File: rtl/msg_rom_tx.sv
module msg_rom_tx #(
  parameter int DIV_A  = 10,
  parameter int DIV_B  = 8,
  parameter int CHAR_W = 9,
  parameter int NCHAR  = 4,
  parameter int GAP    = 3,
  parameter logic [NCHAR*CHAR_W-1:0] MSG = {9'h1A1, 9'h00A, 9'h00D, 9'h153}
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sdata,
  output logic done,
  output logic guard
);
  localparam int FRAME = CHAR_W + 2 + GAP;
  localparam int NBITS = NCHAR * FRAME - GAP;
  localparam int LAST  = NBITS + 1;
  localparam int AW    = $clog2(LAST + 1);
  localparam int DAW   = $clog2(DIV_A);
  localparam int DBW   = $clog2(DIV_B);
  localparam logic [DAW-1:0] DMAX  = DAW'(DIV_A - 1);
  localparam logic [DBW-1:0] BMAX  = DBW'(DIV_B - 1);
  localparam logic [AW-1:0]  AEND  = AW'(LAST);

  logic [DAW-1:0] dcnt;
  logic [DBW-1:0] bcnt;
  logic [AW-1:0]  addr;
  logic           sdata_q;

  function automatic logic rom_bit(input logic [AW-1:0] a);
    int b, k, p;
    if (a == '0 || int'(a) > NBITS) return 1'b1;
    b = int'(a) - 1;
    k = b / FRAME;
    p = b % FRAME;
    if (p == 0) return 1'b0;
    if (p <= CHAR_W) return MSG[k*CHAR_W + p - 1];
    return 1'b1;
  endfunction

  wire eos_n = (addr != AEND);
  wire run   = start && eos_n;
  wire dtc   = (dcnt == DMAX);
  wire btc   = (bcnt == BMAX);

  always_ff @(posedge clk) begin
    if (rst || !run) dcnt <= '0;
    else             dcnt <= dtc ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !start)  bcnt <= '0;
    else if (run && dtc) bcnt <= btc ? '0 : bcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !start)          addr <= '0;
    else if (run && dtc && btc) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !start) sdata_q <= 1'b1;
    else               sdata_q <= rom_bit(addr);
  end

  assign sdata = sdata_q;
  assign done  = !eos_n;
  assign guard = (addr == '0) || !eos_n;
endmodule

// File: rtl/msg_rom_tx_chk.sv
module msg_rom_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic sdata,
  input logic done,
  input logic guard
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !start |=> (sdata && !done && guard));

  assert_end_mark_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> sdata);

  assert_end_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (done && $stable(sdata)));

  assert_guard_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(guard) |-> ($past(start) && !done));

  assert_done_guard_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> guard);

  assert_done_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(start));
endmodule

bind msg_rom_tx msg_rom_tx_chk u_chk (
  .clk(clk), .rst(rst), .start(start),
  .sdata(sdata), .done(done), .guard(guard)
);

// File: tb/sim_msg_rom_tx.sv
`timescale 1ns/1ps
module sim_msg_rom_tx;
  localparam int BITP = 80;
  localparam int LASTA = 54;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sdata, done, guard;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic finished = 1'b0;

  logic [LASTA:0] expv;
  logic [8:0] codes [4];

  int m_addr = 0;
  int m_cnt = 0;
  logic m_sd = 1'b1;

  msg_rom_tx u0 (.clk(clk), .rst(rst), .start(start),
                 .sdata(sdata), .done(done), .guard(guard));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  function automatic logic exp_guard(input int a);
    return (a == 0) || (a == LASTA);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst || !start) begin
      m_addr <= 0; m_cnt <= 0; m_sd <= 1'b1;
    end else begin
      m_sd <= expv[m_addr];
      if (m_addr < LASTA) begin
        if (m_cnt == BITP - 1) begin m_cnt <= 0; m_addr <= m_addr + 1; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(m_addr == LASTA ? "R4" : (start ? "R3" : "R6"), sdata, m_sd);
      chk(m_addr == 0 ? "R1" : "R8", done, m_addr == LASTA);
      chk(m_addr == 0 ? "R1" : "R5", guard, exp_guard(m_addr));
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int pos;
    int t_start;
    codes[0] = 9'h153; codes[1] = 9'h00D; codes[2] = 9'h00A; codes[3] = 9'h1A1;
    expv = '1;
    pos = 1;
    for (int k = 0; k < 4; k++) begin
      expv[pos] = 1'b0; pos++;
      for (int j = 0; j < 9; j++) begin expv[pos] = codes[k][j]; pos++; end
      expv[pos] = 1'b1; pos++;
      if (k < 3) pos += 3;
    end
    void'($urandom(32'd20240611));

    @(negedge clk); @(negedge clk);
    chk("R1", sdata, 1); chk("R1", done, 0); chk("R1", guard, 1);
    rst = 1'b0;
    wait_cycles(5);
    chk("R1", sdata, 1); chk("R1", guard, 1);
    chk("R3", pos, 54);

    start = 1'b1;
    t_start = cyc;
    while (guard) @(negedge clk);
    chk("R2", cyc - t_start, BITP);
    chk("R7", sdata, 1);
    @(negedge clk);
    chk("R7", sdata, 0);
    while (!done) @(negedge clk);
    chk("R2", cyc - t_start, BITP * LASTA);
    wait_cycles(300);
    chk("R4", done, 1); chk("R4", sdata, 1);
    start = 1'b0;
    @(negedge clk);
    chk("R6", done, 0); chk("R6", guard, 1);

    wait_cycles(3);
    start = 1'b1;
    wait_cycles(BITP * 20 + 7);
    chk("R5", guard, 0);
    start = 1'b0;
    @(negedge clk);
    chk("R6", guard, 1); chk("R6", sdata, 1);
    wait_cycles(2);
    start = 1'b1;
    wait_cycles(BITP * LASTA + 3);
    chk("R6", done, 1);
    start = 1'b0;

    for (int it = 0; it < 24; it++) begin
      wait_cycles($urandom_range(1, 20));
      if ($urandom_range(0, 4) == 0) begin
        rst = 1'b1;
        wait_cycles($urandom_range(1, 3));
        rst = 1'b0;
      end
      start = 1'b1;
      wait_cycles($urandom_range(1, 4600));
      start = 1'b0;
    end
    wait_cycles(4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule